// File: doc/BRIEF.md
# Packed Saturating Arithmetic Unit

This unit performs the arithmetic behind DSP-style instructions on a 32-bit datapath. It adds and subtracts four byte lanes or two halfword lanes packed in one word, in signed or unsigned form, and clamps every lane at its range limit instead of letting it wrap. It also clamps a signed 32-bit value to a chosen bit width, performs a full-width add with carry-in that yields carry and signed-overflow flags, performs a full-width add that only reports signed overflow, and takes the absolute difference of unsigned bytes.

Each cycle the unit takes an opcode, two operands, a carry-in and a saturation width. It presents the result and three flags one clock later from registers: a sticky-style saturation indication (Q) for the operation, the carry-out and the overflow. Instruction decode and register reads happen outside the unit; it has no handshake, and a new operation can be issued every cycle.

Lane i of a byte operation occupies bits [8i+7:8i], and lane j of a halfword operation occupies bits [16j+15:16j]. Opcodes are 4 bits: 0 sadd8, 1 ssub8, 2 uadd8, 3 usub8, 4 sadd16, 5 ssub16, 6 uadd16, 7 usub16, 8 signed clamp-to-width, 9 unsigned clamp-to-width, 10 add-with-carry, 11 add with overflow-to-Q, 12 unsigned byte absolute difference, 13 to 15 unused.

Top module: `simd_sat_alu`

## Requirements
- R1: All outputs are registered with one cycle of latency: the values for inputs present at a rising clock edge appear after that edge, and while rst_ni is low result_o, q_o, carry_o and ovf_o are all zero.
- R2: Signed saturating add (op 0 on bytes, op 4 on halfwords): a lane overflows when both operands have equal sign bits and the wrapped sum's sign differs; it then yields 0x7F / 0x7FFF if the first operand is non-negative, else 0x80 / 0x8000.
- R3: Signed saturating subtract (op 1 bytes, op 5 halfwords): a lane overflows when the operands' signs differ and the wrapped difference's sign differs from the first operand; the clamp values are those of R2.
- R4: Unsigned saturating add (op 2 bytes, op 6 halfwords): a lane whose wrapped sum is below its first operand yields all ones (0xFF / 0xFFFF); otherwise the sum.
- R5: Unsigned saturating subtract (op 3 bytes, op 7 halfwords): a lane with first operand not greater than the second yields zero; the lane counts as saturated only when the first operand is strictly smaller.
- R6: Lanes are computed independently with no carry or borrow between them, and q_o is the OR of all lane saturation indications.
- R7: Signed clamp (op 8) of a_i to width n = sat_width_i: with max = 2^n - 1 and t = a_i arithmetically shifted right by n, the result is max if t > 0, NOT max if t < -1, else a_i unchanged; q_o is 1 exactly when clamping happened.
- R8: Unsigned clamp (op 9): a negative a_i yields 0, a value above max = 2^n - 1 yields max, else a_i unchanged; q_o is 1 exactly when clamping happened.
- R9: Add-with-carry (op 10) yields a_i + b_i + carry_i modulo 2^32, carry_o = 1 when the 33-bit sum exceeds 32 bits, ovf_o = 1 when the signed sum differs from the signed 32-bit result; q_o is 0.
- R10: Add with overflow-to-Q (op 11) yields a_i + b_i modulo 2^32 and sets q_o when the operands share a sign and the result's sign differs.
- R11: Absolute difference (op 12) yields, in each byte lane, the larger unsigned operand minus the smaller; q_o is 0.
- R12: carry_o and ovf_o are 0 for every opcode other than 10; opcodes 13 to 15 yield a zero result and zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation select (encoding above) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Carry-in for add-with-carry |
| sat_width_i | input | 5 | Clamp width n for ops 8 and 9 |
| result_o | output | 32 | Registered result |
| q_o | output | 1 | Registered saturation indication |
| carry_o | output | 1 | Registered carry-out |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
The bench aims at the lane edges where signed clamping flips direction: 0x7F+0x01, 0x80+0xFF and 0x00-0x80, where a design that picked the clamp from the result sign or the second operand would return the opposite limit. It checks that equal operands in unsigned subtract give zero without raising Q, and that a halfword add carries from bit 7 into bit 8 while no lane leaks into the next, which a design with the wrong lane split would break. For clamp-to-width it walks the shifted value through the boundary of the pass band (-1, 0, -2, +2) and width zero, where an off-by-one in the shift or the max value shows up at once; the add-with-carry vectors separate carry from overflow, including the case where the carry-in alone causes overflow.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [3:0] {
    OP_SADD8  = 4'd0,
    OP_SSUB8  = 4'd1,
    OP_UADD8  = 4'd2,
    OP_USUB8  = 4'd3,
    OP_SADD16 = 4'd4,
    OP_SSUB16 = 4'd5,
    OP_UADD16 = 4'd6,
    OP_USUB16 = 4'd7,
    OP_SSATW  = 4'd8,
    OP_USATW  = 4'd9,
    OP_ADC    = 4'd10,
    OP_ADDQ   = 4'd11,
    OP_ABSD8  = 4'd12
  } alu_op_e;

  typedef enum logic [2:0] {
    LANE_IDLE  = 3'd0,
    LANE_ADD_S = 3'd1,
    LANE_SUB_S = 3'd2,
    LANE_ADD_U = 3'd3,
    LANE_SUB_U = 3'd4,
    LANE_ABSD  = 3'd5
  } lane_op_e;

endpackage

// File: rtl/simd_sat_lane.sv
module simd_sat_lane
  import simd_sat_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  lane_op_e          op_i,
  output logic [LANE_W-1:0] res_o,
  output logic              sat_o
);

  localparam int MSB = LANE_W - 1;
  localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

  logic [LANE_W-1:0] sum_w, dif_w, rdif_w, clamp_w;
  logic              add_ovf, sub_ovf, a_gt_b;

  assign sum_w   = a_i + b_i;
  assign dif_w   = a_i - b_i;
  assign rdif_w  = b_i - a_i;
  assign clamp_w = a_i[MSB] ? NEG_LIM : POS_LIM;
  assign a_gt_b  = a_i > b_i;
  assign add_ovf = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
  assign sub_ovf = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    unique case (op_i)
      LANE_ADD_S: begin
        res_o = add_ovf ? clamp_w : sum_w;
        sat_o = add_ovf;
      end
      LANE_SUB_S: begin
        res_o = sub_ovf ? clamp_w : dif_w;
        sat_o = sub_ovf;
      end
      LANE_ADD_U: begin
        sat_o = sum_w < a_i;
        res_o = sat_o ? '1 : sum_w;
      end
      LANE_SUB_U: begin
        res_o = a_gt_b ? dif_w : '0;
        sat_o = a_i < b_i;
      end
      LANE_ABSD: res_o = a_gt_b ? dif_w : rdif_w;
      default: ;
    endcase
  end

endmodule

// File: rtl/simd_width_sat.sv
module simd_width_sat #(
  parameter int DATA_W = 32,
  localparam int SW_W  = $clog2(DATA_W)
) (
  input  logic signed [DATA_W-1:0] val_i,
  input  logic [SW_W-1:0]          n_i,
  input  logic                     uns_i,
  output logic [DATA_W-1:0]        res_o,
  output logic                     sat_o
);

  logic [DATA_W-1:0]        max_v;
  logic signed [DATA_W-1:0] top_v;

  assign max_v = (DATA_W'(1) << n_i) - DATA_W'(1);
  assign top_v = val_i >>> n_i;

  always_comb begin
    res_o = val_i;
    sat_o = 1'b0;
    if (!uns_i) begin
      if (top_v > 0) begin
        res_o = max_v;
        sat_o = 1'b1;
      end else if (top_v < -1) begin
        res_o = ~max_v;
        sat_o = 1'b1;
      end
    end else begin
      if (val_i[DATA_W-1]) begin
        res_o = '0;
        sat_o = 1'b1;
      end else if ($unsigned(val_i) > max_v) begin
        res_o = max_v;
        sat_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/simd_adc.sv
module simd_adc #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              ovf_o
);

  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] full_w;

  assign full_w = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o  = full_w[DATA_W-1:0];
  assign cout_o = full_w[DATA_W];
  // signed overflow is only possible when the operands share a sign
  assign ovf_o  = (a_i[MSB] == b_i[MSB]) && (full_w[MSB] != a_i[MSB]);

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SW_W  = $clog2(DATA_W),
  localparam int NUM_B = DATA_W / 8,
  localparam int NUM_H = DATA_W / 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic [SW_W-1:0]   sat_width_i,
  output logic [DATA_W-1:0] result_o,
  output logic              q_o,
  output logic              carry_o,
  output logic              ovf_o
);

  alu_op_e  op_w;
  lane_op_e byte_op, half_op;

  logic [DATA_W-1:0] byte_word, half_word, wsat_res, adc_sum;
  logic [NUM_B-1:0]  byte_sat;
  logic [NUM_H-1:0]  half_sat;
  logic              wsat_sat, adc_cout, adc_ovf, adc_cin;

  logic [DATA_W-1:0] res_d;
  logic              q_d, c_d, v_d;

  assign op_w = alu_op_e'(op_i);

  always_comb begin
    byte_op = LANE_IDLE;
    half_op = LANE_IDLE;
    unique case (op_w)
      OP_SADD8:  byte_op = LANE_ADD_S;
      OP_SSUB8:  byte_op = LANE_SUB_S;
      OP_UADD8:  byte_op = LANE_ADD_U;
      OP_USUB8:  byte_op = LANE_SUB_U;
      OP_ABSD8:  byte_op = LANE_ABSD;
      OP_SADD16: half_op = LANE_ADD_S;
      OP_SSUB16: half_op = LANE_SUB_S;
      OP_UADD16: half_op = LANE_ADD_U;
      OP_USUB16: half_op = LANE_SUB_U;
      default: ;
    endcase
  end

  for (genvar g = 0; g < NUM_B; g++) begin : g_byte
    simd_sat_lane #(.LANE_W(8)) u_lane (
      .a_i  (a_i[g*8 +: 8]),
      .b_i  (b_i[g*8 +: 8]),
      .op_i (byte_op),
      .res_o(byte_word[g*8 +: 8]),
      .sat_o(byte_sat[g])
    );
  end

  for (genvar g = 0; g < NUM_H; g++) begin : g_half
    simd_sat_lane #(.LANE_W(16)) u_lane (
      .a_i  (a_i[g*16 +: 16]),
      .b_i  (b_i[g*16 +: 16]),
      .op_i (half_op),
      .res_o(half_word[g*16 +: 16]),
      .sat_o(half_sat[g])
    );
  end

  simd_width_sat #(.DATA_W(DATA_W)) u_wsat (
    .val_i(a_i),
    .n_i  (sat_width_i),
    .uns_i(op_w == OP_USATW),
    .res_o(wsat_res),
    .sat_o(wsat_sat)
  );

  // one adder serves both full-width adds; carry-in only for add-with-carry
  assign adc_cin = (op_w == OP_ADC) ? carry_i : 1'b0;

  simd_adc #(.DATA_W(DATA_W)) u_adc (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (adc_cin),
    .sum_o (adc_sum),
    .cout_o(adc_cout),
    .ovf_o (adc_ovf)
  );

  always_comb begin
    res_d = '0;
    q_d   = 1'b0;
    c_d   = 1'b0;
    v_d   = 1'b0;
    unique case (op_w)
      OP_SADD8, OP_SSUB8, OP_UADD8, OP_USUB8, OP_ABSD8: begin
        res_d = byte_word;
        q_d   = |byte_sat;
      end
      OP_SADD16, OP_SSUB16, OP_UADD16, OP_USUB16: begin
        res_d = half_word;
        q_d   = |half_sat;
      end
      OP_SSATW, OP_USATW: begin
        res_d = wsat_res;
        q_d   = wsat_sat;
      end
      OP_ADC: begin
        res_d = adc_sum;
        c_d   = adc_cout;
        v_d   = adc_ovf;
      end
      OP_ADDQ: begin
        res_d = adc_sum;
        q_d   = adc_ovf;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      q_o      <= 1'b0;
      carry_o  <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      q_o      <= q_d;
      carry_o  <= c_d;
      ovf_o    <= v_d;
    end
  end

endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SW_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              carry_i,
  input logic [SW_W-1:0]   sat_width_i,
  input logic [DATA_W-1:0] result_o,
  input logic              q_o,
  input logic              carry_o,
  input logic              ovf_o
);

  // set once a full clock edge out of reset has loaded the output registers
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  assert_flags_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) != 4'(OP_ADC)) |-> (!carry_o && !ovf_o));

  assert_usub_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) == 4'(OP_USUB8)) && ($past(a_i[7:0]) < $past(b_i[7:0]))
    |-> (result_o[7:0] == 8'h00) && q_o);

  assert_uadd_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) == 4'(OP_UADD8)) |-> (result_o[7:0] >= $past(a_i[7:0])));

  assert_usat_nonneg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) == 4'(OP_USATW)) |-> !result_o[DATA_W-1]);

  assert_ssat_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) == 4'(OP_SSATW)) && !q_o |-> (result_o == $past(a_i)));

  assert_absd_no_q_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && ($past(op_i) == 4'(OP_ABSD8)) |-> !q_o);

  logic unused_chk;
  assign unused_chk = ^{b_i[DATA_W-1:8], carry_i, sat_width_i};

endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .carry_i    (carry_i),
  .sat_width_i(sat_width_i),
  .result_o   (result_o),
  .q_o        (q_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o)
);

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        carry_i = 1'b0;
  logic [4:0]  sat_width_i = '0;
  logic [31:0] result_o;
  logic        q_o, carry_o, ovf_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  simd_sat_alu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .carry_i(carry_i), .sat_width_i(sat_width_i),
    .result_o(result_o), .q_o(q_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one register stage)
  task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic cin, input logic [4:0] w);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; carry_i = cin; sat_width_i = w;
    @(negedge clk_i);
  endtask

  task automatic expect_all(input string tag, input logic [31:0] r, input logic q,
                            input logic c, input logic v);
    chk({tag, " result"}, result_o, r);
    chk({tag, " q"}, {31'd0, q_o}, {31'd0, q});
    chk({tag, " carry"}, {31'd0, carry_o}, {31'd0, c});
    chk({tag, " ovf"}, {31'd0, ovf_o}, {31'd0, v});
  endtask

  task automatic t_reset_R1;
    op_i = 4'd11; a_i = 32'd5; b_i = 32'd6;
    repeat (3) @(negedge clk_i);
    expect_all("R1 in reset", 32'h0, 1'b0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    #1 chk("R1 latency before edge", result_o, 32'h0);
    @(negedge clk_i);
    expect_all("R1 first op", 32'd11, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sadd_R2;
    run(4'd0, 32'h7F8010F0, 32'h01FF20F0, 1'b0, 5'd0);
    expect_all("R2 sadd8 clamp", 32'h7F8030E0, 1'b1, 1'b0, 1'b0);
    run(4'd4, 32'h7FFF8000, 32'h00018000, 1'b0, 5'd0);
    expect_all("R2 sadd16 clamp", 32'h7FFF8000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ssub_R3;
    run(4'd1, 32'h807F0500, 32'h01FF0780, 1'b0, 5'd0);
    expect_all("R3 ssub8 clamp", 32'h807FFE7F, 1'b1, 1'b0, 1'b0);
    run(4'd5, 32'h80007FFF, 32'h0001FFFF, 1'b0, 5'd0);
    expect_all("R3 ssub16 clamp", 32'h80007FFF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_uadd_R4;
    run(4'd2, 32'hFF801000, 32'h01802000, 1'b0, 5'd0);
    expect_all("R4 uadd8", 32'hFFFF3000, 1'b1, 1'b0, 1'b0);
    run(4'd6, 32'hFFFF1234, 32'h00021111, 1'b0, 5'd0);
    expect_all("R4 uadd16", 32'hFFFF2345, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_usub_R5;
    run(4'd3, 32'h051020FF, 32'h05201000, 1'b0, 5'd0);
    expect_all("R5 usub8", 32'h000010FF, 1'b1, 1'b0, 1'b0);
    run(4'd3, 32'h05050505, 32'h05050505, 1'b0, 5'd0);
    expect_all("R5 usub8 equal", 32'h00000000, 1'b0, 1'b0, 1'b0);
    run(4'd7, 32'h10000003, 32'h20000001, 1'b0, 5'd0);
    expect_all("R5 usub16", 32'h00000002, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_lanes_R6;
    run(4'd0, 32'h01020304, 32'h10101010, 1'b0, 5'd0);
    expect_all("R6 sadd8 no sat", 32'h11121314, 1'b0, 1'b0, 1'b0);
    run(4'd4, 32'h00FF0001, 32'h00010002, 1'b0, 5'd0);
    expect_all("R6 sadd16 inner carry", 32'h01000003, 1'b0, 1'b0, 1'b0);
    run(4'd2, 32'h000000FF, 32'h00000001, 1'b0, 5'd0);
    expect_all("R6 one lane sat", 32'h000000FF, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_ssat_R7;
    run(4'd8, 32'h00000100, 32'h0, 1'b0, 5'd7);
    expect_all("R7 ssat high", 32'h0000007F, 1'b1, 1'b0, 1'b0);
    run(4'd8, 32'hFFFFFF00, 32'h0, 1'b0, 5'd7);
    expect_all("R7 ssat low", 32'hFFFFFF80, 1'b1, 1'b0, 1'b0);
    run(4'd8, 32'hFFFFFFC0, 32'h0, 1'b0, 5'd7);
    expect_all("R7 ssat pass neg", 32'hFFFFFFC0, 1'b0, 1'b0, 1'b0);
    run(4'd8, 32'h0000003F, 32'h0, 1'b0, 5'd7);
    expect_all("R7 ssat pass pos", 32'h0000003F, 1'b0, 1'b0, 1'b0);
    run(4'd8, 32'h00000005, 32'h0, 1'b0, 5'd0);
    expect_all("R7 ssat width0", 32'h00000000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_usat_R8;
    run(4'd9, 32'hFFFFFFFF, 32'h0, 1'b0, 5'd8);
    expect_all("R8 usat neg", 32'h00000000, 1'b1, 1'b0, 1'b0);
    run(4'd9, 32'h00000300, 32'h0, 1'b0, 5'd8);
    expect_all("R8 usat high", 32'h000000FF, 1'b1, 1'b0, 1'b0);
    run(4'd9, 32'h000000FF, 32'h0, 1'b0, 5'd8);
    expect_all("R8 usat at max", 32'h000000FF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_adc_R9;
    run(4'd10, 32'hFFFFFFFF, 32'h0, 1'b1, 5'd0);
    expect_all("R9 adc carry", 32'h00000000, 1'b0, 1'b1, 1'b0);
    run(4'd10, 32'h7FFFFFFF, 32'h0, 1'b1, 5'd0);
    expect_all("R9 adc cin ovf", 32'h80000000, 1'b0, 1'b0, 1'b1);
    run(4'd10, 32'h80000000, 32'h80000000, 1'b0, 5'd0);
    expect_all("R9 adc both", 32'h00000000, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_addq_R10;
    run(4'd11, 32'h7FFFFFFF, 32'h00000001, 1'b1, 5'd0);
    expect_all("R10 addq pos ovf", 32'h80000000, 1'b1, 1'b0, 1'b0);
    run(4'd11, 32'h80000000, 32'hFFFFFFFF, 1'b0, 5'd0);
    expect_all("R10 addq neg ovf", 32'h7FFFFFFF, 1'b1, 1'b0, 1'b0);
    run(4'd11, 32'd5, 32'd6, 1'b0, 5'd0);
    expect_all("R10 addq plain", 32'd11, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_absd_R11;
    run(4'd12, 32'h10FF0080, 32'h2001007F, 1'b0, 5'd0);
    expect_all("R11 absdiff", 32'h10FE0001, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_other_R12;
    run(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 5'd3);
    expect_all("R12 unused op", 32'h00000000, 1'b0, 1'b0, 1'b0);
    run(4'd13, 32'h12345678, 32'h1, 1'b1, 5'd0);
    expect_all("R12 unused op13", 32'h00000000, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset_R1();
    t_sadd_R2();
    t_ssub_R3();
    t_uadd_R4();
    t_usub_R5();
    t_lanes_R6();
    t_ssat_R7();
    t_usat_R8();
    t_adc_R9();
    t_addq_R10();
    t_absd_R11();
    t_other_R12();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule